// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations that sits in front of a page table. Each lookup carries a virtual page number, an address-space identifier and a page offset. Every stored entry is compared against the request at once. On a hit, the physical address is built from the stored frame number with the offset appended unchanged. On a miss, the block reports that the page table must be consulted. An external walker then loads the missing translation through a plain refill port.

Every entry carries the identifier of the address space that owns it. Translations of the same page number for different processes can therefore live side by side, and a hit needs both the page number and the identifier to agree. A flush input invalidates all entries at once.

Lookups and results each travel on a valid/ready stream. A request is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. Its result appears on the next cycle. The result stays on the output, unchanged, until `res_ready` is high at a clock edge. While a result is held, `lk_ready` is low, so a request waiting upstream is stalled rather than lost. The refill and flush inputs are single-cycle control strobes with no handshake.

Top module: `tlb_asid`

## Requirements
- R1: A lookup hits when any valid entry holds the requested page number and identifier. All entries are compared in the same cycle.
- R2: An entry matches only when its stored identifier equals the request identifier. The same page number may be stored under different identifiers, and each copy translates independently.
- R3: A miss is reported as `res_valid`=1 with `res_hit`=0, and in that case `res_paddr` is all zeros.
- R4: When several entries match, the frame number of the lowest-index matching entry is returned.
- R5: On a hit, `res_paddr` equals the frame number in the upper PFN_W bits concatenated with the request offset in the lower OFF_W bits.
- R6: A request accepted at a clock edge produces `res_valid`=1 with its result immediately after the next edge. Result registers are updated only on acceptance or consumption.
- R7: `lk_ready` equals `!res_valid || res_ready`. A result that is not consumed stays on the outputs with its value stable.
- R8: Reset and `flush` invalidate every entry and return the replacement pointer to entry 0. A refill in the same cycle as a flush is dropped.
- R9: A refill (`fill_en`=1) writes the lowest-index invalid entry. When every entry is valid, it writes the entry named by a round-robin pointer, and the pointer then advances by one, wrapping from ENTRIES-1 to 0.
- R10: After reset, `res_valid` and `res_hit` are 0 and `lk_ready` is 1.
- R11: A lookup in the same cycle as a refill or flush sees the table contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_vpn | input | VPN_W | Virtual page number of the request |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| lk_off | input | OFF_W | Page offset of the request |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Downstream takes the result |
| res_hit | output | 1 | 1 = translation found, 0 = page-table lookup needed |
| res_paddr | output | PFN_W+OFF_W | Physical address on a hit, zero on a miss |
| fill_en | input | 1 | Refill strobe from the external walker |
| fill_vpn | input | VPN_W | Page number to store |
| fill_asid | input | ASID_W | Identifier to store |
| fill_pfn | input | PFN_W | Frame number to store |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest situations to reach from the ports are a table holding duplicate keys and the round-robin replacement path, which only runs once every entry is valid. The bench uses a four-entry instance. It fills the table completely, with one key deliberately stored twice, and then keeps refilling. This lets it observe the lowest-index priority first, and then see which copy is evicted as the pointer steps around. Directed tests then hold a result under back-pressure while a different request waits, and issue a flush in the same cycle as a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Source of the entry selected for the next refill.
  typedef enum logic {
    VIC_FREE = 1'b0,  // lowest-index invalid entry
    VIC_RR   = 1'b1   // table full: round-robin pointer
  } vic_src_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = vld[g] && (ent_vpn[g] == key_vpn) && (ent_asid[g] == key_asid);
  end

  // Scan from the top down so that the lowest matching index is the one left.
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   vic_idx,
  output vic_src_e           vic_src
);
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign vic_src = (&vld) ? VIC_RR : VIC_FREE;
  assign vic_idx = (vic_src == VIC_RR) ? rr_ptr : free_idx;
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 16,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  output logic                   lk_ready,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic [OFF_W-1:0]       lk_off,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic                   res_hit,
  output logic [PFN_W+OFF_W-1:0] res_paddr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  // Entry storage
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic [IDX_W-1:0] vic_idx;
  vic_src_e         vic_src;
  logic             accept;
  logic             do_fill;

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_match (
    .vld(vld_q), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .key_vpn(lk_vpn), .key_asid(lk_asid),
    .hit(m_hit), .idx(m_idx)
  );

  tlb_victim #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .vld(vld_q), .rr_ptr(rr_q), .vic_idx(vic_idx), .vic_src(vic_src)
  );

  assign lk_ready = !res_valid || res_ready;
  assign accept   = lk_valid && lk_ready;
  assign do_fill  = fill_en && !flush;

  // Valid bits and replacement pointer
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      vld_q[vic_idx] <= 1'b1;
      if (vic_src == VIC_RR) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  // Entry payload, no reset needed
  always_ff @(posedge clk) begin
    if (do_fill) begin
      ent_vpn[vic_idx]  <= fill_vpn;
      ent_asid[vic_idx] <= fill_asid;
      ent_pfn[vic_idx]  <= fill_pfn;
    end
  end

  // Result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_hit   <= m_hit;
      res_paddr <= m_hit ? {ent_pfn[m_idx], lk_off} : PA_W'(0);
    end else if (res_ready) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end
  end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
  parameter int ENTRIES = 8,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic [OFF_W-1:0]   lk_off,
  input logic               res_valid,
  input logic               res_ready,
  input logic               res_hit,
  input logic [PA_W-1:0]    res_paddr,
  input logic               fill_en,
  input logic               flush,
  input logic [ENTRIES-1:0] vld
);
  AST_ACCEPT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_paddr))); // R7

  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !lk_ready); // R7

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_paddr == '0)); // R3

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_off))); // R5

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0)); // R8

  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> (vld != '0)); // R9
endmodule

bind tlb_asid tlb_asid_chk #(
  .ENTRIES(ENTRIES), .OFF_W(OFF_W), .PA_W(PFN_W + OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_off(lk_off), .res_valid(res_valid), .res_ready(res_ready),
  .res_hit(res_hit), .res_paddr(res_paddr), .fill_en(fill_en),
  .flush(flush), .vld(vld_q)
);

// File: tb/tlb_asid_tb.sv
module tlb_asid_tb;
  localparam int ENT = 4, VW = 8, AW = 4, PW = 6, OW = 4, PAW = PW + OW;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, res_ready = 1, fill_en = 0, flush = 0;
  logic lk_ready, res_valid, res_hit;
  logic [VW-1:0] lk_vpn = 0, fill_vpn = 0;
  logic [AW-1:0] lk_asid = 0, fill_asid = 0;
  logic [OW-1:0] lk_off = 0;
  logic [PW-1:0] fill_pfn = 0;
  logic [PAW-1:0] res_paddr;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tlb_asid #(.ENTRIES(ENT), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW), .OFF_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_off(lk_off),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_paddr(res_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_pfn(fill_pfn), .flush(flush));

  // Vector word: [31] op (0 refill, 1 lookup), [30:23] vpn, [22:19] asid,
  // [18:13] pfn, [12:9] offset, [8] expected hit, [7:2] expected pfn.
  function automatic logic [31:0] vf(input int v, input int a, input int p);
    return {1'b0, 8'(v), 4'(a), 6'(p), 4'd0, 1'b0, 6'd0, 2'd0};
  endfunction
  function automatic logic [31:0] vl(input int v, input int a, input int o, input int h, input int p);
    return {1'b1, 8'(v), 4'(a), 6'd0, 4'(o), 1'(h), 6'(p), 2'd0};
  endfunction

  localparam int NV = 17;
  localparam logic [31:0] VEC [NV] = '{
    vf(8'h10, 1, 6'h05),             // entry 0
    vf(8'h10, 2, 6'h06),             // entry 1, same page other ASID
    vf(8'h22, 1, 6'h07),             // entry 2
    vl(8'h10, 1, 3, 1, 6'h05),       // R1 R5
    vl(8'h10, 2, 15, 1, 6'h06),      // R2
    vl(8'h10, 3, 0, 0, 0),           // R2 R3
    vl(8'h22, 2, 0, 0, 0),           // R2 R3
    vl(8'h22, 1, 0, 1, 6'h07),       // R1
    vf(8'h10, 1, 6'h2A),             // duplicate key into entry 3
    vl(8'h10, 1, 1, 1, 6'h05),       // R4 lowest index wins
    vf(8'h33, 1, 6'h11),             // full: evicts entry 0 (pointer 0)
    vl(8'h10, 1, 2, 1, 6'h2A),       // R9 copy in entry 3 now answers
    vl(8'h33, 1, 4, 1, 6'h11),       // R9
    vf(8'h44, 1, 6'h12),             // evicts entry 1 (pointer 1)
    vl(8'h10, 2, 5, 0, 0),           // R9 evicted
    vl(8'h44, 1, 9, 1, 6'h12),       // R9
    vl(8'h22, 1, 7, 1, 6'h07)        // R9 entry 2 untouched
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic refill(input int v, input int a, input int p);
    @(negedge clk);
    fill_en = 1; fill_vpn = VW'(v); fill_asid = AW'(a); fill_pfn = PW'(p);
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic lookup(input string req, input int v, input int a, input int o,
                        input logic h, input int p);
    @(negedge clk);
    lk_valid = 1; lk_vpn = VW'(v); lk_asid = AW'(a); lk_off = OW'(o);
    @(negedge clk);
    lk_valid = 0;
    chk({req, " R6 valid"}, 32'(res_valid), 32'd1);
    chk({req, " hit"}, 32'(res_hit), 32'(h));
    chk({req, " paddr"}, 32'(res_paddr), h ? 32'({PW'(p), OW'(o)}) : 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 res_valid", 32'(res_valid), 0);
    chk("R10 res_hit", 32'(res_hit), 0);
    chk("R10 lk_ready", 32'(lk_ready), 1);
    rst_n = 1;
    lookup("R8 empty after reset", 8'h10, 1, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      if (!VEC[i][31]) refill(int'(VEC[i][30:23]), int'(VEC[i][22:19]), int'(VEC[i][18:13]));
      else lookup($sformatf("vec%0d R1", i), int'(VEC[i][30:23]), int'(VEC[i][22:19]),
                  int'(VEC[i][12:9]), VEC[i][8], int'(VEC[i][7:2]));
    end

    // R7 back-pressure: result held, waiting request stalled, then both move.
    @(negedge clk);
    res_ready = 0; lk_valid = 1; lk_vpn = 8'h44; lk_asid = 1; lk_off = 4'h3;
    @(negedge clk);
    lk_vpn = 8'h99;
    chk("R7 ready low", 32'(lk_ready), 0);
    chk("R7 held hit", 32'(res_hit), 1);
    @(negedge clk);
    chk("R7 held paddr", 32'(res_paddr), 32'({6'h12, 4'h3}));
    chk("R7 held valid", 32'(res_valid), 1);
    res_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    chk("R7 second result miss", 32'(res_hit), 0);
    chk("R7 second result valid", 32'(res_valid), 1);
    @(negedge clk);
    chk("R7 drained", 32'(res_valid), 0);

    // R11 lookup in the refill cycle sees old contents.
    @(negedge clk);
    fill_en = 1; fill_vpn = 8'h55; fill_asid = 2; fill_pfn = 6'h21;
    lk_valid = 1; lk_vpn = 8'h55; lk_asid = 2; lk_off = 0;
    @(negedge clk);
    fill_en = 0; lk_valid = 0;
    chk("R11 same-cycle miss", 32'(res_hit), 0);
    lookup("R11 next cycle hit", 8'h55, 2, 6, 1, 6'h21);

    // R8 flush clears everything; flush beats a refill in the same cycle.
    @(negedge clk);
    flush = 1; fill_en = 1; fill_vpn = 8'h66; fill_asid = 1; fill_pfn = 6'h01;
    @(negedge clk);
    flush = 0; fill_en = 0;
    lookup("R8 flushed entry", 8'h44, 1, 0, 0, 0);
    lookup("R8 dropped refill", 8'h66, 1, 0, 0, 0);

    // R9 after flush refills land in free entries; full table then starts at pointer 0.
    refill(8'h70, 1, 6'h30);
    refill(8'h71, 1, 6'h31);
    refill(8'h72, 1, 6'h32);
    refill(8'h73, 1, 6'h33);
    refill(8'h74, 1, 6'h34); // replaces entry 0 (0x70)
    lookup("R9 pointer reset by flush", 8'h70, 1, 0, 0, 0);
    lookup("R9 entry 1 kept", 8'h71, 1, 2, 1, 6'h31);
    lookup("R9 new entry", 8'h74, 1, 8, 1, 6'h34);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule